// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block collects up to 32 interrupt sources and turns them into two request lines and one wake line for a processor. For each source, software picks a trigger kind with a three-bit code: rising edge, falling edge, either edge, active-high level or active-low level. It also sets an enable (mask) bit, a wake-enable bit, a routing bit and a general select bit. Inputs pass through a two-flop synchroniser. A detected edge is held in a sticky capture register until software clears it.

Every configuration register can be reached at three word addresses: one that reads its value, one that sets bits, and one that clears bits. A write to the set or clear address changes only the bit positions written as one. This lets two software agents change different sources without a read-modify-write sequence. Two read-only pending registers, one per request line, show the sources that are currently asserting that line. The request and wake outputs are registered ORs of the pending and wake terms.

Top module: `intc_core`

## Requirements
- R1: After reset, every readable register reads 0, and `req0_o`, `req1_o` and `wake_o` are 0.
- R2: The address is `{group[3:0], offset[1:0]}`. Offset 0 reads, offset 1 sets and offset 2 clears. The configuration groups are 0 mode bit 0, 1 mode bit 1, 2 mode bit 2, 3 select, 4 route, 5 wake enable and 6 mask. A one in `wdata` at the set or clear offset sets or clears that bit, and a zero leaves it unchanged. A read at any of the three offsets returns the register value one cycle after `rd_en`, with `rvalid_o` high.
- R3: The trigger code of source n is {mode2[n], mode1[n], mode0[n]}: 001 rising, 010 falling, 011 either edge, 101 high level, 110 low level. Codes 000, 100 and 111 are disabled: a disabled source never captures an edge and never becomes pending.
- R4: An edge that the code enables sets a sticky bit in the rise capture register (group 7) or the fall capture register (group 8). The bit stays set after the input returns, until a one is written to offset 2 of that group.
- R5: Level codes do not latch. A level source is pending only while its synchronised input is at the active level.
- R6: A source is pending only while its mask bit is 1. While the mask bit is 0, a captured edge is kept, and it makes the source pending once the mask bit is set again.
- R7: A pending source with route bit 1 appears in pending register 0 (group 9). A pending source with route bit 0 appears in pending register 1 (group 10), never in both.
- R8: `req0_o` and `req1_o` are the OR of pending register 0 and pending register 1, registered once.
- R9: `wake_o` is high one cycle after any source is active (edge captured or level asserted, per its code) with its wake bit set, regardless of its mask bit.
- R10: For a level source, an input change reaches the request output at the third rising clock edge after the change: two edges in the synchroniser and one in the output register.
- R11: Group 11 is a one-bit test register. Offset 1 loads `wdata[0]`, and offset 0 reads it back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Asynchronous interrupt source inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register address {group, offset} |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake output |

## Verification
The hardest situation to reach from the ports is a captured edge that survives a window with its mask bit clear. The source must be set to an edge code with its mask off, then pulsed, and then the input must settle. The bench then reads the capture register to see that the edge was kept, and checks that no request rose. Only after that does it set the mask bit and watch the request appear. The disabled codes 100 and 111 are driven with full pulses and held levels, with wake and mask enabled. This shows that neither edges nor levels leak through those codes.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned GRP_W    = 4;
  localparam int unsigned OFF_W    = 2;
  localparam int unsigned ADDR_W   = GRP_W + OFF_W;
  localparam int unsigned NUM_CFG  = 7;

  localparam logic [GRP_W-1:0] G_MODE0 = 4'd0;
  localparam logic [GRP_W-1:0] G_MODE1 = 4'd1;
  localparam logic [GRP_W-1:0] G_MODE2 = 4'd2;
  localparam logic [GRP_W-1:0] G_SEL   = 4'd3;
  localparam logic [GRP_W-1:0] G_ROUTE = 4'd4;
  localparam logic [GRP_W-1:0] G_WAKE  = 4'd5;
  localparam logic [GRP_W-1:0] G_MASK  = 4'd6;
  localparam logic [GRP_W-1:0] G_RISE  = 4'd7;
  localparam logic [GRP_W-1:0] G_FALL  = 4'd8;
  localparam logic [GRP_W-1:0] G_PEND0 = 4'd9;
  localparam logic [GRP_W-1:0] G_PEND1 = 4'd10;
  localparam logic [GRP_W-1:0] G_TEST  = 4'd11;

  localparam logic [OFF_W-1:0] OFF_RD  = 2'd0;
  localparam logic [OFF_W-1:0] OFF_SET = 2'd1;
  localparam logic [OFF_W-1:0] OFF_CLR = 2'd2;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_BOTH = 3'b011,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;
endpackage

// File: rtl/intc_sync_edge.sv
module intc_sync_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;
  logic [N-1:0] s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = irq_i;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      cfg_o [NUM_CFG],
  output logic              test_o
);
  logic [N-1:0] cfg_q [NUM_CFG];
  logic [N-1:0] cfg_d [NUM_CFG];
  logic [NUM_CFG-1:0] cfg_en;
  logic test_q, test_d, test_en;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam logic [GRP_W-1:0] GC = GRP_W'(g);
    logic hit_set, hit_clr;
    assign hit_set   = wr_en && (addr == {GC, OFF_SET});
    assign hit_clr   = wr_en && (addr == {GC, OFF_CLR});
    assign cfg_en[g] = hit_set | hit_clr;
    assign cfg_d[g]  = hit_set ? (cfg_q[g] | wdata) : (cfg_q[g] & ~wdata);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[g] <= '0;
      else if (cfg_en[g]) cfg_q[g] <= cfg_d[g];
    end

    assign cfg_o[g] = cfg_q[g];
  end

  assign test_en = wr_en && (addr == {G_TEST, OFF_SET});
  assign test_d  = wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       test_q <= 1'b0;
    else if (test_en) test_q <= test_d;
  end

  assign test_o = test_q;
endmodule

// File: rtl/intc_trigger.sv
module intc_trigger
  import intc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] mode0,
  input  logic [N-1:0] mode1,
  input  logic [N-1:0] mode2,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic [N-1:0] rise_clr,
  input  logic [N-1:0] fall_clr,
  output logic [N-1:0] rcap_o,
  output logic [N-1:0] fcap_o,
  output logic [N-1:0] active_o
);
  logic [N-1:0] rise_en, fall_en, hi_en, lo_en;
  logic [N-1:0] rcap_q, fcap_q, rcap_d, fcap_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    trig_e code;
    assign code = trig_e'({mode2[i], mode1[i], mode0[i]});
    always_comb begin
      rise_en[i] = 1'b0;
      fall_en[i] = 1'b0;
      hi_en[i]   = 1'b0;
      lo_en[i]   = 1'b0;
      case (code)
        TRIG_RISE: rise_en[i] = 1'b1;
        TRIG_FALL: fall_en[i] = 1'b1;
        TRIG_BOTH: begin rise_en[i] = 1'b1; fall_en[i] = 1'b1; end
        TRIG_HIGH: hi_en[i] = 1'b1;
        TRIG_LOW:  lo_en[i] = 1'b1;
        default:   ;
      endcase
    end
  end

  // a new edge wins over a clear written in the same cycle
  always_comb begin
    rcap_d = (rcap_q & ~rise_clr) | (rise & rise_en);
    fcap_d = (fcap_q & ~fall_clr) | (fall & fall_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcap_q <= '0;
      fcap_q <= '0;
    end else begin
      rcap_q <= rcap_d;
      fcap_q <= fcap_d;
    end
  end

  assign rcap_o   = rcap_q;
  assign fcap_o   = fcap_q;
  assign active_o = (hi_en & lvl) | (lo_en & ~lvl) |
                    (rise_en & rcap_q) | (fall_en & fcap_q);
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               rvalid_o,
  output logic               req0_o,
  output logic               req1_o,
  output logic               wake_o
);
  logic rst_m_q, rst_s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [NUM_SRC-1:0] lvl, rise, fall;
  logic [NUM_SRC-1:0] cfg [NUM_CFG];
  logic               test_q;
  logic [NUM_SRC-1:0] mode0, mode1, mode2, sel, route, wake_en, mask;
  logic [NUM_SRC-1:0] rise_clr, fall_clr, rcap, fcap, active;
  logic [NUM_SRC-1:0] pend0, pend1;

  intc_sync_edge #(.N(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_s_q), .irq_i(irq_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  intc_regs #(.N(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_s_q), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .cfg_o(cfg), .test_o(test_q)
  );

  assign mode0   = cfg[G_MODE0];
  assign mode1   = cfg[G_MODE1];
  assign mode2   = cfg[G_MODE2];
  assign sel     = cfg[G_SEL];
  assign route   = cfg[G_ROUTE];
  assign wake_en = cfg[G_WAKE];
  assign mask    = cfg[G_MASK];

  assign rise_clr = (wr_en && addr == {G_RISE, OFF_CLR}) ? wdata : '0;
  assign fall_clr = (wr_en && addr == {G_FALL, OFF_CLR}) ? wdata : '0;

  intc_trigger #(.N(NUM_SRC)) u_trig (
    .clk(clk), .rst_n(rst_s_q),
    .mode0(mode0), .mode1(mode1), .mode2(mode2),
    .lvl(lvl), .rise(rise), .fall(fall),
    .rise_clr(rise_clr), .fall_clr(fall_clr),
    .rcap_o(rcap), .fcap_o(fcap), .active_o(active)
  );

  assign pend0 = active & mask & route;
  assign pend1 = active & mask & ~route;

  logic [NUM_SRC-1:0] rd_sel, rdata_q, rdata_d;
  logic rvalid_q, rvalid_d, req0_q, req0_d, req1_q, req1_d, wake_q, wake_d;

  always_comb begin
    case (addr[ADDR_W-1:OFF_W])
      G_MODE0: rd_sel = mode0;
      G_MODE1: rd_sel = mode1;
      G_MODE2: rd_sel = mode2;
      G_SEL:   rd_sel = sel;
      G_ROUTE: rd_sel = route;
      G_WAKE:  rd_sel = wake_en;
      G_MASK:  rd_sel = mask;
      G_RISE:  rd_sel = rcap;
      G_FALL:  rd_sel = fcap;
      G_PEND0: rd_sel = pend0;
      G_PEND1: rd_sel = pend1;
      G_TEST:  rd_sel = {{(NUM_SRC-1){1'b0}}, test_q};
      default: rd_sel = '0;
    endcase
    rdata_d  = rd_sel;
    rvalid_d = rd_en;
    req0_d   = |pend0;
    req1_d   = |pend1;
    wake_d   = |(active & wake_en);
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      req0_q   <= 1'b0;
      req1_q   <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rdata_d;
      rvalid_q <= rvalid_d;
      req0_q   <= req0_d;
      req1_q   <= req1_d;
      wake_q   <= wake_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign req0_o   = req0_q;
  assign req1_o   = req1_q;
  assign wake_o   = wake_q;
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
  import intc_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      mask,
  input logic [N-1:0]      pend0,
  input logic [N-1:0]      pend1,
  input logic [N-1:0]      rcap,
  input logic              rvalid_o,
  input logic              req0_o,
  input logic              req1_o
);
  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0 | pend1) & ~mask) == '0);

  // R7
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 & pend1) == '0);

  // R8
  req0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend0) |=> req0_o);

  // R8
  req0_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend0) |=> !req0_o);

  // R8
  req1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend1) |=> req1_o);

  // R4
  rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == {G_RISE, OFF_CLR}) |=> ((rcap & $past(rcap)) == $past(rcap)));

  // R2
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_o);
endmodule

bind intc_core intc_core_chk #(.N(NUM_SRC)) chk_i (
  .clk(clk), .rst_n(rst_s_q), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .mask(mask), .pend0(pend0), .pend1(pend1), .rcap(rcap),
  .rvalid_o(rvalid_o), .req0_o(req0_o), .req1_o(req1_o)
);

// File: tb/intc_core_tb_top.sv
module intc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_i = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, req0_o, req1_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0]  a;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #5 clk = ~clk;

  intc_core #(.NUM_SRC(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  function automatic logic [5:0] A(input int g, input int off);
    return {4'(g), 2'(off)};
  endfunction

  // monitor: pops expected read items as read data comes back
  always @(negedge clk) begin
    if (rvalid_o) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read data %h expected none", rdata_o);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rdata_o !== it.exp) begin
          errors++;
          $display("FAIL %s addr %h actual %h expected %h", it.tag, it.a, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.a = a; it.exp = e; it.tag = tag;
    @(negedge clk);
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_pin(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cleanup();
    for (int g = 0; g < 9; g++) bus_wr(A(g, 2), 32'hFFFF_FFFF);
    bus_wr(A(11, 1), 32'h0);
    tick(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk_pin("R1 req0", req0_o, 1'b0);
    chk_pin("R1 req1", req1_o, 1'b0);
    chk_pin("R1 wake", wake_o, 1'b0);
    for (int g = 0; g < 12; g++) bus_rd(A(g, 0), 32'h0, "R1 reset read");

    // R2 set/clear semantics and read at all offsets
    bus_wr(A(0, 1), 32'h0000_00F0);
    bus_rd(A(0, 0), 32'h0000_00F0, "R2 read off0");
    bus_rd(A(0, 1), 32'h0000_00F0, "R2 read off1");
    bus_rd(A(0, 2), 32'h0000_00F0, "R2 read off2");
    bus_wr(A(0, 1), 32'h0000_000F);
    bus_rd(A(0, 0), 32'h0000_00FF, "R2 set keeps zeros");
    bus_wr(A(0, 2), 32'h0000_0030);
    bus_rd(A(0, 0), 32'h0000_00CF, "R2 clear");
    bus_wr(A(3, 1), 32'hA5A5_0000);
    bus_rd(A(3, 0), 32'hA5A5_0000, "R2 select reg");
    bus_wr(A(3, 2), 32'hFFFF_FFFF);
    bus_rd(A(3, 0), 32'h0, "R2 select cleared");
    cleanup();

    // R3/R4 rising edge, source 0, route to line 0
    bus_wr(A(0, 1), 32'h1);
    bus_wr(A(4, 1), 32'h1);
    bus_wr(A(6, 1), 32'h1);
    irq_i[0] = 1'b1; tick(4);
    chk_pin("R3 rising req0", req0_o, 1'b1);
    irq_i[0] = 1'b0; tick(4);
    bus_rd(A(7, 0), 32'h1, "R4 rise sticky");
    bus_rd(A(8, 0), 32'h0, "R3 no fall in rise mode");
    bus_rd(A(9, 0), 32'h1, "R7 pend0");
    bus_rd(A(10, 0), 32'h0, "R7 pend1 empty");
    chk_pin("R4 req0 held", req0_o, 1'b1);
    bus_wr(A(7, 2), 32'h1);
    tick(2);
    bus_rd(A(9, 0), 32'h0, "R4 rise cleared");
    chk_pin("R8 req0 drop", req0_o, 1'b0);
    cleanup();

    // R3 falling edge, source 1, route to line 1
    bus_wr(A(1, 1), 32'h2);
    bus_wr(A(6, 1), 32'h2);
    irq_i[1] = 1'b1; tick(4);
    bus_rd(A(8, 0), 32'h0, "R3 no capture on rise");
    chk_pin("R3 falling req1 idle", req1_o, 1'b0);
    irq_i[1] = 1'b0; tick(4);
    bus_rd(A(8, 0), 32'h2, "R3 fall capture");
    bus_rd(A(10, 0), 32'h2, "R7 pend1");
    chk_pin("R7 req1", req1_o, 1'b1);
    chk_pin("R7 req0 idle", req0_o, 1'b0);
    cleanup();

    // R3 either edge, source 2
    bus_wr(A(0, 1), 32'h4);
    bus_wr(A(1, 1), 32'h4);
    bus_wr(A(4, 1), 32'h4);
    bus_wr(A(6, 1), 32'h4);
    irq_i[2] = 1'b1; tick(4);
    irq_i[2] = 1'b0; tick(4);
    bus_rd(A(7, 0), 32'h4, "R3 either rise");
    bus_rd(A(8, 0), 32'h4, "R3 either fall");
    bus_wr(A(7, 2), 32'h4);
    bus_rd(A(9, 0), 32'h4, "R4 fall capture keeps pending");
    bus_wr(A(8, 2), 32'h4);
    bus_rd(A(9, 0), 32'h0, "R4 both cleared");
    cleanup();

    // R5/R10 high level, source 3
    bus_wr(A(2, 1), 32'h8);
    bus_wr(A(0, 1), 32'h8);
    bus_wr(A(4, 1), 32'h8);
    bus_wr(A(6, 1), 32'h8);
    irq_i[3] = 1'b1; tick(2);
    chk_pin("R10 req0 after two edges", req0_o, 1'b0);
    tick(1);
    chk_pin("R10 req0 after three edges", req0_o, 1'b1);
    bus_rd(A(9, 0), 32'h8, "R5 level pending");
    bus_rd(A(7, 0), 32'h0, "R5 level not captured");
    irq_i[3] = 1'b0; tick(4);
    bus_rd(A(9, 0), 32'h0, "R5 level released");
    chk_pin("R5 req0 released", req0_o, 1'b0);

    // R9 wake with mask clear
    bus_wr(A(6, 2), 32'h8);
    bus_wr(A(5, 1), 32'h8);
    irq_i[3] = 1'b1; tick(4);
    chk_pin("R9 wake set", wake_o, 1'b1);
    chk_pin("R6 masked req0", req0_o, 1'b0);
    irq_i[3] = 1'b0; tick(4);
    chk_pin("R9 wake cleared", wake_o, 1'b0);
    cleanup();

    // R3 low level, source 4, route to line 1
    bus_wr(A(2, 1), 32'h10);
    bus_wr(A(1, 1), 32'h10);
    bus_wr(A(6, 1), 32'h10);
    tick(3);
    chk_pin("R3 low level req1", req1_o, 1'b1);
    bus_rd(A(10, 0), 32'h10, "R3 low level pend1");
    irq_i[4] = 1'b1; tick(4);
    bus_rd(A(10, 0), 32'h0, "R3 low level inactive");
    chk_pin("R3 low level req1 off", req1_o, 1'b0);
    cleanup();
    irq_i[4] = 1'b0; tick(4);

    // R3 disabled codes 100 (source 5) and 111 (source 6)
    bus_wr(A(2, 1), 32'h60);
    bus_wr(A(1, 1), 32'h40);
    bus_wr(A(0, 1), 32'h40);
    bus_wr(A(4, 1), 32'h60);
    bus_wr(A(5, 1), 32'h60);
    bus_wr(A(6, 1), 32'h60);
    irq_i[6:5] = 2'b11; tick(4);
    chk_pin("R3 code100/111 no req0", req0_o, 1'b0);
    chk_pin("R3 code100/111 no wake", wake_o, 1'b0);
    irq_i[6:5] = 2'b00; tick(4);
    bus_rd(A(7, 0), 32'h0, "R3 disabled no rise capture");
    bus_rd(A(8, 0), 32'h0, "R3 disabled no fall capture");
    bus_rd(A(9, 0), 32'h0, "R3 disabled not pending");
    cleanup();

    // R6 capture survives mask clear
    bus_wr(A(0, 1), 32'h1);
    bus_wr(A(4, 1), 32'h1);
    irq_i[0] = 1'b1; tick(4);
    irq_i[0] = 1'b0; tick(4);
    bus_rd(A(7, 0), 32'h1, "R6 capture while masked");
    bus_rd(A(9, 0), 32'h0, "R6 masked not pending");
    chk_pin("R6 masked req0", req0_o, 1'b0);
    bus_wr(A(6, 1), 32'h1);
    tick(1);
    chk_pin("R6 unmask req0", req0_o, 1'b1);
    bus_rd(A(9, 0), 32'h1, "R6 unmask pending");
    cleanup();

    // R11 test register
    bus_wr(A(11, 1), 32'h1);
    bus_rd(A(11, 0), 32'h1, "R11 test set");
    bus_wr(A(11, 1), 32'h0);
    bus_rd(A(11, 0), 32'h0, "R11 test cleared");

    tick(4);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule